// File: doc/BRIEF.md
# Timer Base with Update Control

This block is the time base of a general-purpose timer: a 16-bit up-counter fed by a programmable prescaler, with a small register file on a simple write/read port. The counter runs while its enable bit is set. It wraps to zero after reaching the active reload value, and each wrap is an overflow update event. An update event can also come from a software strobe or from an external trigger input. Any update event copies the staged prescaler and reload values into the registers that the counter uses.

Software decides which update sources are reported. It can also suppress update events completely, stop the counter after its next update (single-shot operation), and choose whether reload writes apply at once or wait for the next update. A sticky update flag drives a level interrupt/DMA request that software can mask. The 32-bit counter view can carry the flag in its top bit. The block also produces a sampling-clock enable that pulses every 1, 2 or 4 timer clocks.

Top module: `tmr_base`

## Requirements
- R1: After reset every register reads zero. Register addresses: 0 control, 1 interrupt enable (bit 0), 2 status (bit 0 = update flag), 3 event generation (bit 0 = update strobe), 4 counter view, 5 prescaler, 6 reload. Control bits: 0 count enable, 1 update disable, 2 report only overflows, 3 single-shot, 7 reload preload, 9:8 sampling division, 11 flag mirroring. Control bits 15:12, 10 and 6:4 always read 0.
- R2: While counting with prescaler value P, the counter advances once every P+1 clocks. One tick after it reaches the active reload value it returns to 0, and that wrap is an overflow update event.
- R3: With preload off, a reload write takes effect at once. With preload on, the written value becomes active only at the next update event. Reading the reload and prescaler addresses returns the staged values.
- R4: Writing 1 to bit 0 of the event generation register clears the counter and the prescaler and makes an update event. `update_evt` is high for one clock, in the cycle after the write edge.
- R5: In single-shot mode an update event clears the count enable bit, so the counter stops at 0.
- R6: With overflow-only reporting, software and trigger updates still load the staged values but do not set the flag. Overflows still set it.
- R7: With update disable set, no source produces an update event: staged values are not loaded and the flag stays clear. The counter still wraps, and a strobe still clears the counter.
- R8: The counter view returns the counter in bits 15:0. Bit 31 shows the update flag while mirroring is on and reads 0 while it is off.
- R9: `samp_en` is high on every clock for division code 00 or 11, on one clock in 2 for code 01, and on one clock in 4 for code 10.
- R10: The update flag stays set until software writes 0 to status bit 0. Writing 1 there has no effect. `update_irq` is high exactly while the flag and the interrupt enable are both 1.
- R11: A one-cycle pulse on `ext_trig` acts like the software strobe: it clears the counter and the prescaler and makes an update event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational |
| ext_trig | input | 1 | External update trigger |
| update_evt | output | 1 | One-clock pulse per update event |
| update_irq | output | 1 | Update interrupt/DMA request level |
| samp_en | output | 1 | Sampling-clock enable |

## Verification
A stale active reload or prescaler value shows up as a wrong wrap point. The counter view reveals it within one counting period, so the sweep checks the count after every edge of several periods. If a wrong source is allowed to set the flag, `update_irq` and bit 31 of the counter view change on the very next clock. A missed single-shot stop shows up one tick later as a nonzero count. An error in the division counter changes how many `samp_en` pulses appear in an eight-clock window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 3;
    localparam int VIEW_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_IEN  = 3'd1,
        A_STAT = 3'd2,
        A_EGEN = 3'd3,
        A_CNT  = 3'd4,
        A_PSC  = 3'd5,
        A_ARR  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic       mirror;
        logic [1:0] div;
        logic       preload;
        logic       oneshot;
        logic       ovf_only;
        logic       upd_off;
        logic       run;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [15:0] w);
        ctrl_t c;
        c.run      = w[0];
        c.upd_off  = w[1];
        c.ovf_only = w[2];
        c.oneshot  = w[3];
        c.preload  = w[7];
        c.div      = w[9:8];
        c.mirror   = w[11];
        return c;
    endfunction

    function automatic logic [15:0] ctrl_pack(input ctrl_t c);
        logic [15:0] w;
        w      = '0;
        w[0]   = c.run;
        w[1]   = c.upd_off;
        w[2]   = c.ovf_only;
        w[3]   = c.oneshot;
        w[7]   = c.preload;
        w[9:8] = c.div;
        w[11]  = c.mirror;
        return w;
    endfunction
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         restart,
    input  logic         load,
    input  logic [W-1:0] psc_stage,
    output logic         tick
);
    logic [W-1:0] psc_act;
    logic [W-1:0] div_cnt;

    assign tick = run && (div_cnt == psc_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_act <= '0;
            div_cnt <= '0;
        end else begin
            if (load) psc_act <= psc_stage;
            if (restart || tick) div_cnt <= '0;
            else if (run)        div_cnt <= div_cnt + 1'b1;
        end
    end

    assert_psc_restart_R4: assert property (@(posedge clk) disable iff (rst)
        restart |=> (div_cnt == '0));
endmodule

// File: rtl/tmr_sampdiv.sv
module tmr_sampdiv #(
    parameter int DW = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] div,
    output logic       samp_en
);
    logic [DW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 1'b1;
    end

    always_comb begin
        unique case (div)
            2'b01:   samp_en = (phase[0] == 1'b0);
            2'b10:   samp_en = (phase == '0);
            default: samp_en = 1'b1;
        endcase
    end

    assert_half_rate_R9: assert property (@(posedge clk) disable iff (rst)
        (div == 2'b01 && samp_en) |=> (div != 2'b01 || !samp_en));
endmodule

// File: rtl/tmr_base.sv
module tmr_base
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [VIEW_W-1:0] rd_data,
    input  logic              ext_trig,
    output logic              update_evt,
    output logic              update_irq,
    output logic              samp_en
);
    ctrl_t            ctrl;
    logic             uie;
    logic             flag;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] arr_act;
    logic [CNT_W-1:0] arr_stage;
    logic [CNT_W-1:0] psc_stage;
    logic             evt_q;

    logic wr_ctrl, wr_stat, wr_cnt, wr_arr, wr_psc, wr_ien;
    logic sw_strobe, forced, tick, ovf, uev, flag_set;

    assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
    assign wr_ien    = wr_en && (wr_addr == A_IEN);
    assign wr_stat   = wr_en && (wr_addr == A_STAT);
    assign wr_cnt    = wr_en && (wr_addr == A_CNT);
    assign wr_psc    = wr_en && (wr_addr == A_PSC);
    assign wr_arr    = wr_en && (wr_addr == A_ARR);
    assign sw_strobe = wr_en && (wr_addr == A_EGEN) && wr_data[0];
    assign forced    = sw_strobe || ext_trig;

    assign ovf      = tick && (cnt == arr_act);
    assign uev      = !ctrl.upd_off && (ovf || forced);
    assign flag_set = uev && (!ctrl.ovf_only || ovf);

    tmr_presc #(.W(CNT_W)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl.run),
        .restart   (forced),
        .load      (uev),
        .psc_stage (psc_stage),
        .tick      (tick)
    );

    tmr_sampdiv #(.DW(2)) u_sampdiv (
        .clk     (clk),
        .rst     (rst),
        .div     (ctrl.div),
        .samp_en (samp_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            uie       <= 1'b0;
            flag      <= 1'b0;
            cnt       <= '0;
            arr_act   <= '0;
            arr_stage <= '0;
            psc_stage <= '0;
            evt_q     <= 1'b0;
        end else begin
            evt_q <= uev;

            if (wr_ctrl)                     ctrl     <= ctrl_unpack(wr_data);
            else if (uev && ctrl.oneshot)    ctrl.run <= 1'b0;

            if (wr_ien) uie <= wr_data[0];
            if (wr_psc) psc_stage <= wr_data;

            if (wr_arr) arr_stage <= wr_data;
            if (uev)    arr_act   <= arr_stage;
            if (wr_arr && !ctrl.preload) arr_act <= wr_data;

            if (flag_set)                   flag <= 1'b1;
            else if (wr_stat && !wr_data[0]) flag <= 1'b0;

            if (forced)      cnt <= '0;
            else if (wr_cnt) cnt <= wr_data;
            else if (tick)   cnt <= ovf ? '0 : cnt + 1'b1;
        end
    end

    assign update_evt = evt_q;
    assign update_irq = flag && uie;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:  rd_data[15:0]      = ctrl_pack(ctrl);
            A_IEN:   rd_data[0]         = uie;
            A_STAT:  rd_data[0]         = flag;
            A_CNT: begin
                rd_data[CNT_W-1:0]      = cnt;
                rd_data[VIEW_W-1]       = ctrl.mirror && flag;
            end
            A_PSC:   rd_data[CNT_W-1:0] = psc_stage;
            A_ARR:   rd_data[CNT_W-1:0] = arr_stage;
            default: rd_data            = '0;
        endcase
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == arr_act && !forced && !wr_cnt) |=> (cnt == '0));
    assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (rst)
        (update_evt && ctrl.oneshot && !$past(wr_ctrl)) |-> !ctrl.run);
    assert_quiet_source_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.ovf_only && forced && !tick && !flag) |=> !flag);
    assert_upd_off_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.upd_off && !flag) |=> (!flag && !update_evt));
    assert_sticky_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (flag && !wr_stat) |=> flag);
endmodule

// File: tb/tmr_base_bench.sv
module tmr_base_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;
    logic        ext_trig;
    logic        update_evt;
    logic        update_irq;
    logic        samp_en;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    tmr_base u_tmr_base (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_trig(ext_trig), .update_evt(update_evt),
        .update_irq(update_irq), .samp_en(samp_en)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a; #1;
        d = rd_data;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    logic [31:0] v;

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; ext_trig = 1'b0;
        edges(3);
        @(negedge clk); rst = 1'b0;
        edges(1);

        // R1 reset state and reserved bits
        rd(3'd0, v); chk("R1 ctrl reset", v, 32'h0);
        rd(3'd4, v); chk("R1 count reset", v, 32'h0);
        rd(3'd2, v); chk("R1 status reset", v, 32'h0);
        chk("R1 irq reset", {31'b0, update_irq}, 32'h0);
        chk("R1 evt reset", {31'b0, update_evt}, 32'h0);
        wr(3'd0, 16'hFFFF);
        rd(3'd0, v); chk("R1 reserved read zero", v, 32'h0B8F);
        wr(3'd0, 16'h0000);

        // R2 counting sweep over prescaler and reload
        for (int p = 0; p < 3; p++) begin
            for (int a = 1; a < 4; a++) begin
                wr(3'd0, 16'h0000);
                wr(3'd5, 16'(p));
                wr(3'd6, 16'(a));
                wr(3'd3, 16'h0001);
                wr(3'd2, 16'h0000);
                wr(3'd0, 16'h0001);
                for (int k = 1; k <= 12; k++) begin
                    @(posedge clk); #1;
                    rd(3'd4, v);
                    chk("R2 count sweep", v, 32'((k / (p + 1)) % (a + 1)));
                end
            end
        end
        wr(3'd0, 16'h0000);
        wr(3'd5, 16'h0000);

        // R3 preload on: new reload waits for an update
        wr(3'd0, 16'h0080);
        wr(3'd6, 16'd3);
        wr(3'd3, 16'h0001);
        rd(3'd6, v); chk("R3 staged reload readback", v, 32'd3);
        wr(3'd6, 16'd6);
        wr(3'd0, 16'h0081);
        edges(3);  rd(3'd4, v); chk("R3 old reload active", v, 32'd3);
        edges(2);  rd(3'd4, v); chk("R3 wrap at old reload", v, 32'd1);
        edges(5);  rd(3'd4, v); chk("R3 new reload after update", v, 32'd6);
        edges(1);  rd(3'd4, v); chk("R3 wrap at new reload", v, 32'd0);
        // R3 preload off: immediate
        wr(3'd0, 16'h0000);
        wr(3'd6, 16'd2);
        wr(3'd4, 16'd2);
        wr(3'd0, 16'h0001);
        edges(1);  rd(3'd4, v); chk("R3 immediate reload", v, 32'd0);
        wr(3'd0, 16'h0000);

        // R4 software strobe
        wr(3'd4, 16'd1);
        wr(3'd2, 16'h0000);
        wr(3'd3, 16'h0001);
        chk("R4 evt pulse", {31'b0, update_evt}, 32'd1);
        rd(3'd4, v); chk("R4 strobe clears count", v, 32'd0);
        edges(1);
        chk("R4 evt one cycle", {31'b0, update_evt}, 32'd0);

        // R10 sticky flag and request
        rd(3'd2, v); chk("R10 flag set by strobe", v, 32'd1);
        wr(3'd2, 16'h0001);
        rd(3'd2, v); chk("R10 write 1 ignored", v, 32'd1);
        chk("R10 irq masked", {31'b0, update_irq}, 32'd0);
        wr(3'd1, 16'h0001);
        chk("R10 irq raised", {31'b0, update_irq}, 32'd1);

        // R8 flag mirroring
        wr(3'd0, 16'h0800);
        rd(3'd4, v); chk("R8 bit31 mirrors flag", v, 32'h8000_0000);
        wr(3'd2, 16'h0000);
        chk("R10 irq cleared", {31'b0, update_irq}, 32'd0);
        rd(3'd4, v); chk("R8 bit31 follows clear", v, 32'h0);
        wr(3'd3, 16'h0001);
        wr(3'd0, 16'h0000);
        rd(3'd4, v); chk("R8 bit31 zero when off", v, 32'h0);

        // R11 external trigger
        wr(3'd2, 16'h0000);
        wr(3'd4, 16'd1);
        @(negedge clk); ext_trig = 1'b1;
        @(posedge clk); #1; ext_trig = 1'b0;
        rd(3'd4, v); chk("R11 trigger clears count", v, 32'd0);
        rd(3'd2, v); chk("R11 trigger sets flag", v, 32'd1);
        chk("R11 trigger event", {31'b0, update_evt}, 32'd1);

        // R6 overflow-only reporting (active reload 2)
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'h0084);
        wr(3'd6, 16'd4);
        wr(3'd3, 16'h0001);
        rd(3'd2, v); chk("R6 strobe silent", v, 32'd0);
        wr(3'd0, 16'h0085);
        edges(4);  rd(3'd4, v); chk("R6 strobe loaded reload", v, 32'd4);
        rd(3'd2, v); chk("R6 flag clear before ovf", v, 32'd0);
        edges(1);  rd(3'd2, v); chk("R6 overflow sets flag", v, 32'd1);
        wr(3'd0, 16'h0084);
        wr(3'd2, 16'h0000);
        @(negedge clk); ext_trig = 1'b1;
        @(posedge clk); #1; ext_trig = 1'b0;
        rd(3'd2, v); chk("R6 trigger silent", v, 32'd0);

        // R7 update disable (active reload 4)
        wr(3'd0, 16'h0082);
        wr(3'd6, 16'd1);
        wr(3'd4, 16'd3);
        wr(3'd3, 16'h0001);
        chk("R7 no event", {31'b0, update_evt}, 32'd0);
        rd(3'd4, v); chk("R7 strobe still clears", v, 32'd0);
        rd(3'd2, v); chk("R7 flag clear", v, 32'd0);
        wr(3'd0, 16'h0083);
        edges(5);  rd(3'd4, v); chk("R7 wraps at unchanged reload", v, 32'd0);
        rd(3'd2, v); chk("R7 overflow silent", v, 32'd0);
        wr(3'd0, 16'h0000);

        // R5 single-shot
        wr(3'd6, 16'd2);
        wr(3'd3, 16'h0001);
        wr(3'd0, 16'h0009);
        edges(3);
        rd(3'd0, v); chk("R5 enable cleared", v, 32'h0008);
        edges(4);
        rd(3'd4, v); chk("R5 counter stopped", v, 32'd0);

        // R9 sampling enable per division code
        for (int c = 0; c < 4; c++) begin
            int n;
            wr(3'd0, 16'(c << 8));
            n = 0;
            for (int i = 0; i < 8; i++) begin
                @(posedge clk); #1;
                if (samp_en) n++;
            end
            chk("R9 sample pulses", 32'(n), (c == 1) ? 32'd4 : (c == 2) ? 32'd2 : 32'd8);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule